// File: doc/BRIEF.md
# SMBus Write-Address Match and Alert Monitor

This block sits beside a two-wire management bus and only listens. It samples the clock and data lines, finds start, repeated-start and stop conditions, counts bits and bytes, and decides whether a transfer was a write to a 7-bit target address that software has programmed. The address-match status is not raised when the address goes by. It is raised only when the transfer ends cleanly: the acknowledge of the last byte completes and a stop or a repeated start follows. If the clock line stays low for too long before that point, the pending match is dropped.

The block also latches an active-low alert input, but only while a function-select input enables the alert function. It reports whether the bus is busy, whatever master started the cycle. Software reaches the status, the enables and the target address through a small register port. A single level interrupt output is the OR of every status bit whose enable is set. The block never drives the bus lines.

Top module: `smb_watch`

## Requirements
- R1: Bit 2 of register 0 (busy, read-only) becomes 1 after a start condition (data falls while clock is high) and returns to 0 after a stop condition (data rises while clock is high).
- R2: Bit 0 of register 0 (match status) is set when a cycle whose first byte carries the address held in register 2 bits 6:0 with direction bit 0 (write) ends with a stop after a completed acknowledge. It stays 0 while that cycle is still in progress, even after the address byte has been acknowledged.
- R3: A cycle to the programmed address with direction bit 1 (read) never sets the match status.
- R4: A write cycle to any other address never sets the match status.
- R5: If the clock line stays low for more than TIMEOUT_CYC clock cycles after an address match and before the closing stop, the match status stays 0 for that cycle.
- R6: A repeated start that follows a completed acknowledge also closes a matching write segment and sets the match status.
- R7: Writing 1 to bit 0 or bit 1 of register 0 clears that status bit. Writing 0 leaves it unchanged.
- R8: Bit 1 of register 0 (alert status) is set while the alert input is low only if the function-select input is 1. With the select input at 0 a low alert input has no effect.
- R9: The interrupt output is 1 exactly when the match status and enable bit 0 of register 1 are both 1, or when the alert status, enable bit 1 of register 1 and the function-select input are all 1.
- R10: After reset all status and enable bits are 0, the bus reads idle and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| alert_n_i | input | 1 | Active-low alert line |
| alert_sel_i | input | 1 | 1 selects the alert function |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 status, 1 enables, 2 target address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the bus lines change far more slowly than the system clock, so every level lasts long enough to cross the synchronizer. They also assume that data changes while the clock line is high only to form start and stop conditions. The bench drives the bus with half-bit periods of several clock cycles. It moves the data line only while the clock line is low, except inside the start, repeated-start and stop routines. It compares its model only after a settling gap that follows each bus or register operation. The only long clock-low interval is the deliberate timeout stall.

// File: rtl/smb_watch_pkg.sv
// Package: shared register indices, bit positions and the bus event type.
package smb_watch_pkg;
    localparam logic [1:0] REG_STAT  = 2'd0;
    localparam logic [1:0] REG_EN    = 2'd1;
    localparam logic [1:0] REG_TADDR = 2'd2;

    localparam int BIT_MATCH = 0;
    localparam int BIT_ALERT = 1;
    localparam int BIT_BUSY  = 2;

    // One-cycle bus events derived from the synchronized lines.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;
endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings the bus lines and the alert line into the clock domain through a
// chain of STAGES flops, then derives start/stop and clock-edge pulses.
// Assumes line changes are slow compared with clk.
module smb_line_sync
    import smb_watch_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    input  logic    alert_n_i,
    output bus_ev_t ev,
    output logic    alert_act
);
    localparam int LAST = STAGES - 1;

    logic [2:0] stage_q [STAGES];
    logic       scl_prev_q;
    logic       sda_prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the line samples one stage down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= 3'b111;
                end else if (g == 0) begin
                    stage_q[g] <= {alert_n_i, sda_i, scl_i};
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= stage_q[LAST][0];
            sda_prev_q <= stage_q[LAST][1];
        end
    end

    // Decode bus events from current and previous levels.
    always_comb begin
        ev.scl      = stage_q[LAST][0];
        ev.sda      = stage_q[LAST][1];
        ev.scl_rise = ev.scl && !scl_prev_q;
        ev.scl_fall = !ev.scl && scl_prev_q;
        ev.start    = ev.scl && scl_prev_q && sda_prev_q && !ev.sda;
        ev.stop     = ev.scl && scl_prev_q && !sda_prev_q && ev.sda;
    end

    assign alert_act = !stage_q[LAST][2];
endmodule

// File: rtl/smb_frame.sv
// Module: smb_frame
// Follows bits and bytes of each transfer. It flags a pending match when the
// first byte after a (repeated) start holds the target address with a write
// direction, and emits a commit pulse when a stop or repeated start arrives
// on a byte boundary. Clock low for TIMEOUT_CYC cycles drops tracking until
// the next start. Assumes the event pulses from smb_line_sync.
module smb_frame
    import smb_watch_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_ev_t    ev,
    input  logic [6:0] target_addr,
    output logic       busy,
    output logic       pend,
    output logic       commit,
    output logic       timeout
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYC - 1);

    logic          busy_q;
    logic          active_q;
    logic          rose_q;
    logic          first_q;
    logic          pend_q;
    logic [3:0]    cnt_q;
    logic [7:0]    shift_q;
    logic [TW-1:0] to_q;

    // A commit needs a pending match and a finished acknowledge.
    assign commit  = (ev.start || ev.stop) && active_q && pend_q && (cnt_q == 4'd0);
    assign timeout = active_q && !ev.scl && (to_q == TO_LAST);
    assign busy    = busy_q;
    assign pend    = pend_q;

    // Track transfer state, bit count and address comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            active_q <= 1'b0;
            rose_q   <= 1'b0;
            first_q  <= 1'b0;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            shift_q  <= '0;
            to_q     <= '0;
        end else if (ev.start) begin
            busy_q   <= 1'b1;
            active_q <= 1'b1;
            rose_q   <= 1'b0;
            first_q  <= 1'b1;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            to_q     <= '0;
        end else if (ev.stop) begin
            busy_q   <= 1'b0;
            active_q <= 1'b0;
            pend_q   <= 1'b0;
        end else if (timeout) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            to_q     <= '0;
        end else if (active_q) begin
            to_q <= ev.scl ? '0 : to_q + 1'b1;
            if (ev.scl_rise) begin
                shift_q <= {shift_q[6:0], ev.sda};
                rose_q  <= 1'b1;
            end
            if (ev.scl_fall && rose_q) begin
                rose_q <= 1'b0;
                if (cnt_q == 4'd8) begin
                    cnt_q   <= '0;
                    first_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                if (first_q && cnt_q == 4'd7) begin
                    pend_q <= (shift_q[7:1] == target_addr) && !shift_q[0];
                end
            end
        end
    end
endmodule

// File: rtl/smb_regs.sv
// Module: smb_regs
// Holds write-one-to-clear status bits, the enable bits and the target
// address, returns read data and forms the interrupt level. A hardware set
// wins over a clear written in the same cycle.
module smb_regs
    import smb_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       commit,
    input  logic       alert_act,
    input  logic       alert_sel,
    input  logic       busy,
    output logic [7:0] reg_rdata,
    output logic [6:0] target_addr,
    output logic       match_sts,
    output logic       alert_sts,
    output logic       irq
);
    logic match_en_q;
    logic alert_en_q;
    logic clr_stat;

    assign clr_stat = reg_wr && (reg_addr == REG_STAT);

    // Update status, enables and target address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_sts   <= 1'b0;
            alert_sts   <= 1'b0;
            match_en_q  <= 1'b0;
            alert_en_q  <= 1'b0;
            target_addr <= '0;
        end else begin
            if (commit) begin
                match_sts <= 1'b1;
            end else if (clr_stat && reg_wdata[BIT_MATCH]) begin
                match_sts <= 1'b0;
            end
            if (alert_sel && alert_act) begin
                alert_sts <= 1'b1;
            end else if (clr_stat && reg_wdata[BIT_ALERT]) begin
                alert_sts <= 1'b0;
            end
            if (reg_wr && reg_addr == REG_EN) begin
                match_en_q <= reg_wdata[0];
                alert_en_q <= reg_wdata[1];
            end
            if (reg_wr && reg_addr == REG_TADDR) begin
                target_addr <= reg_wdata[6:0];
            end
        end
    end

    // Select read data by register index.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_STAT: begin
                reg_rdata[BIT_MATCH] = match_sts;
                reg_rdata[BIT_ALERT] = alert_sts;
                reg_rdata[BIT_BUSY]  = busy;
            end
            REG_EN:    reg_rdata[1:0] = {alert_en_q, match_en_q};
            REG_TADDR: reg_rdata[6:0] = target_addr;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = (match_sts && match_en_q) || (alert_sts && alert_en_q && alert_sel);
endmodule

// File: rtl/smb_watch.sv
// Module: smb_watch (top)
// Passive bus monitor: line synchronizer, transfer tracker and register file.
// Assumes bus lines are slow compared with clk; never drives the bus.
module smb_watch
    import smb_watch_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       alert_n_i,
    input  logic       alert_sel_i,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o
);
    bus_ev_t    ev;
    logic       alert_act;
    logic [6:0] target_addr;
    logic       busy;
    logic       pend;
    logic       commit;
    logic       timeout;
    logic       match_sts;
    logic       alert_sts;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .alert_n_i (alert_n_i),
        .ev        (ev),
        .alert_act (alert_act)
    );

    smb_frame #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .target_addr (target_addr),
        .busy        (busy),
        .pend        (pend),
        .commit      (commit),
        .timeout     (timeout)
    );

    smb_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .commit      (commit),
        .alert_act   (alert_act),
        .alert_sel   (alert_sel_i),
        .busy        (busy),
        .reg_rdata   (reg_rdata),
        .target_addr (target_addr),
        .match_sts   (match_sts),
        .alert_sts   (alert_sts),
        .irq         (irq_o)
    );
endmodule

// File: rtl/smb_watch_chk.sv
// Module: smb_watch_chk
// Temporal checks on the monitor, bound into every smb_watch instance.
module smb_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       alert_sel_i,
    input logic       irq_o,
    input logic       match_sts,
    input logic       alert_sts,
    input logic       busy,
    input logic       pend,
    input logic       commit,
    input logic       timeout,
    input logic       stop_seen
);
    // R2: match status rises only after a commit pulse from the tracker.
    a_r2_set_by_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_sts) |-> $past(commit));

    // R5: a timeout leaves no pending match behind.
    a_r5_timeout_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !pend);

    // R7: a written 1 clears match status unless a commit coincides.
    a_r7_w1c_match: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[0] && !commit) |=> !match_sts);

    // R8: alert status rises only with the function selected.
    a_r8_alert_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_sts) |-> $past(alert_sel_i));

    // R9: no interrupt without some status bit set.
    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (match_sts || alert_sts));

    // R1: a stop leaves the bus idle.
    a_r1_stop_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !busy);
endmodule

bind smb_watch smb_watch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .alert_sel_i (alert_sel_i),
    .irq_o       (irq_o),
    .match_sts   (match_sts),
    .alert_sts   (alert_sts),
    .busy        (busy),
    .pend        (pend),
    .commit      (commit),
    .timeout     (timeout),
    .stop_seen   (ev.stop)
);

// File: tb/smb_watch_tb.sv
// Bench: behavioural transaction model compared with the ports on every idle clock.
module smb_watch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 8;
    localparam int TO_CYC     = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       alert_n = 1'b1;
    logic       alert_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    // Model state
    bit       m_match, m_alert, m_busy, m_men, m_aen, m_pend, m_first;
    bit [6:0] m_target;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smb_watch #(.TIMEOUT_CYC(TO_CYC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda),
        .alert_n_i   (alert_n),
        .alert_sel_i (alert_sel),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison with the model while the design is settled.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            chk("R2 match", {7'd0, reg_rdata[0]}, {7'd0, m_match});
            chk("R8 alert", {7'd0, reg_rdata[1]}, {7'd0, m_alert});
            chk("R1 busy",  {7'd0, reg_rdata[2]}, {7'd0, m_busy});
            chk("R9 irq",   {7'd0, irq},
                {7'd0, (m_match & m_men) | (m_alert & m_aen & alert_sel)});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic quiet();
        wait_clk(6);
        chk_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        chk_en = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
        if (a == 2'd0) begin
            if (d[0]) m_match = 1'b0;
            if (d[1] && !(alert_sel && !alert_n)) m_alert = 1'b0;
        end
        if (a == 2'd1) begin m_men = d[0]; m_aen = d[1]; end
        if (a == 2'd2) m_target = d[6:0];
        quiet();
    endtask

    task automatic bus_start();
        chk_en = 1'b0;
        sda = 1'b1; wait_clk(HB);
        scl = 1'b1; wait_clk(HB);
        sda = 1'b0; wait_clk(HB);
        scl = 1'b0; wait_clk(HB);
        if (m_busy && m_pend) m_match = 1'b1;
        m_busy = 1'b1; m_first = 1'b1; m_pend = 1'b0;
        quiet();
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    wait_clk(HB);
        scl = 1'b1; wait_clk(HB);
        scl = 1'b0; wait_clk(HB);
    endtask

    task automatic bus_byte(input logic [7:0] b);
        chk_en = 1'b0;
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_bit(1'b0);
        if (m_first) begin
            m_pend  = (b[7:1] == m_target) && !b[0];
            m_first = 1'b0;
        end
        quiet();
    endtask

    task automatic bus_stop();
        chk_en = 1'b0;
        sda = 1'b0; wait_clk(HB);
        scl = 1'b1; wait_clk(HB);
        sda = 1'b1; wait_clk(HB);
        if (m_pend) m_match = 1'b1;
        m_busy = 1'b0; m_pend = 1'b0;
        quiet();
    endtask

    task automatic bus_stall();
        chk_en = 1'b0;
        scl = 1'b0; wait_clk(TO_CYC + 60);
        m_pend = 1'b0;
        quiet();
    endtask

    initial begin
        wait_clk(200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R10: reset state
        @(negedge clk);
        chk("R10 status", reg_rdata, 8'h00);
        chk("R10 irq", {7'd0, irq}, 8'h00);
        quiet();

        reg_write(2'd2, 8'h2A);
        reg_write(2'd1, 8'h01);

        // R2: matching write, status only after stop
        bus_start();
        @(negedge clk); chk("R1 busy after start", {7'd0, reg_rdata[2]}, 8'h01);
        bus_byte({7'h2A, 1'b0});
        bus_byte(8'h5C);
        @(negedge clk); chk("R2 not before stop", {7'd0, reg_rdata[0]}, 8'h00);
        bus_stop();
        @(negedge clk); chk("R2 set after stop", {7'd0, reg_rdata[0]}, 8'h01);
        chk("R9 irq match", {7'd0, irq}, 8'h01);

        // R7: writing 0 keeps, writing 1 clears
        reg_write(2'd0, 8'h00);
        @(negedge clk); chk("R7 zero keeps", {7'd0, reg_rdata[0]}, 8'h01);
        reg_write(2'd0, 8'h01);
        @(negedge clk); chk("R7 one clears", {7'd0, reg_rdata[0]}, 8'h00);

        // R3: read direction
        bus_start(); bus_byte({7'h2A, 1'b1}); bus_byte(8'hFF); bus_stop();
        @(negedge clk); chk("R3 read ignored", {7'd0, reg_rdata[0]}, 8'h00);

        // R4: other address
        bus_start(); bus_byte({7'h2B, 1'b0}); bus_byte(8'h00); bus_stop();
        @(negedge clk); chk("R4 other addr", {7'd0, reg_rdata[0]}, 8'h00);

        // R5: timeout between match and final acknowledge
        bus_start(); bus_byte({7'h2A, 1'b0});
        bus_bit(1'b1); bus_bit(1'b0);
        bus_stall();
        bus_stop();
        @(negedge clk); chk("R5 timeout cancels", {7'd0, reg_rdata[0]}, 8'h00);
        chk("R1 idle after stop", {7'd0, reg_rdata[2]}, 8'h00);

        // R6: repeated start closes a matching write
        bus_start(); bus_byte({7'h2A, 1'b0}); bus_byte(8'h11);
        bus_start();
        @(negedge clk); chk("R6 restart commits", {7'd0, reg_rdata[0]}, 8'h01);
        bus_byte({7'h2A, 1'b1}); bus_stop();
        reg_write(2'd1, 8'h00);
        @(negedge clk); chk("R9 masked match", {7'd0, irq}, 8'h00);
        reg_write(2'd0, 8'h01);

        // R8/R9: alert with and without selection
        reg_write(2'd1, 8'h02);
        chk_en = 1'b0;
        alert_n = 1'b0; wait_clk(10);
        @(negedge clk); chk("R8 deselected", {7'd0, reg_rdata[1]}, 8'h00);
        alert_sel = 1'b1; m_alert = 1'b1;
        quiet();
        @(negedge clk); chk("R8 selected", {7'd0, reg_rdata[1]}, 8'h01);
        chk("R9 irq alert", {7'd0, irq}, 8'h01);
        chk_en = 1'b0;
        alert_n = 1'b1;
        quiet();
        alert_sel = 1'b0;
        @(negedge clk); chk("R9 alert needs sel", {7'd0, irq}, 8'h00);
        reg_write(2'd0, 8'h02);
        @(negedge clk); chk("R7 alert clears", {7'd0, reg_rdata[1]}, 8'h00);

        wait_clk(5);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule